// File: doc/BRIEF.md
# Miniature Paged Address Translator

This block maps an 8-bit virtual address onto an 8-bit physical address through a page table with one entry per virtual page. It is a single level, and its eight entries sit in flip-flops inside the block. A host fills the table through a configuration port, one entry at a time. Each entry has a validity flag, a physical frame number and a write-protect attribute.

A requester presents a virtual address with a read/write flag and a request strobe. One cycle later the block returns a response strobe with one of two results: the physical address, or one of two fault flags. The page fault flag means the page is unmapped. The protection fault flag means a write hit a write-protected page.

The three high address bits select the virtual page. The five low bits are the byte offset in a 32-byte page and pass through unchanged. Several virtual pages may name the same frame. This aliasing is legal, and each of those pages translates in the normal way.

Top module: `xlat_mmu`

## Requirements
- R1: After a synchronous reset every table entry is invalid, so a translation of any page reports a page fault, and rsp_valid is low.
- R2: rsp_valid is high in the cycle after a clock edge that samples req_valid high, and low in the cycle after an edge that samples it low.
- R3: A table entry uses bit 7 as the valid flag and bits 6:4 as the frame number. For a valid entry with no fault, rsp_paddr is the frame number in bits 7:5 followed by the request's offset bits 4:0. The page index is request address bits 7:5.
- R4: A request to a page whose entry has bit 7 clear raises rsp_page_fault. With it, rsp_prot_fault is low and rsp_paddr is zero.
- R5: Entry bit 3 is write-protect. A write (req_write=1) to a valid page with bit 3 set raises rsp_prot_fault with rsp_paddr zero. A read of that page translates normally.
- R6: Two or more virtual pages holding the same frame number each translate to that frame without fault.
- R7: Entry bits 2:0 have no effect on any translation result.
- R8: When a table write and a translation address the same entry in the same cycle, the translation uses the entry's old value. The new value applies from the next request onward.
- R9: The two fault flags are never high together, and both are low whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 3 | Index of the entry being written |
| cfg_entry | input | 8 | New entry value |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | 8 | Virtual address |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | 8 | Translated physical address, zero on a fault |
| rsp_page_fault | output | 1 | The page is unmapped |
| rsp_prot_fault | output | 1 | A write hit a write-protected page |

## Verification
The hardest case to reach from the ports is a table write and a translation that hit the same entry on the same clock edge. A bench that configures first and translates afterwards never puts the two in one cycle. The stimulus drives cfg_we and req_valid together at the same falling edge, with the same page index. It checks that the response carries the old frame, and then issues a second request that must show the new one. A reset applied in the middle of the run then checks that a table that was already populated goes back to all-invalid.

// File: rtl/xlat_pkg.sv
// Package xlat_pkg
// Purpose: address split, entry bit positions and the stored entry type
//          shared by the translator modules.
// Assumes: the entry bit positions are fixed by the software that writes
//          the table, so they are not parameters.
package xlat_pkg;
    localparam int VPN_W   = 3;                 // virtual page number bits
    localparam int OFF_W   = 5;                 // byte offset bits
    localparam int VA_W    = VPN_W + OFF_W;     // virtual address width
    localparam int PFN_W   = 3;                 // physical frame bits
    localparam int PA_W    = PFN_W + OFF_W;     // physical address width
    localparam int ENTRY_W = 8;                 // written entry width
    localparam int N_PAGES = 1 << VPN_W;        // table depth

    localparam int BIT_VALID = 7;
    localparam int BIT_PFN_L = 4;
    localparam int BIT_WP    = 3;

    // Fields of an entry that the table keeps; the reserved bits are dropped
    typedef struct packed {
        logic             valid;
        logic [PFN_W-1:0] pfn;
        logic             wprot;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);
endpackage

// File: rtl/xlat_table.sv
// Module xlat_table
// Purpose: holds one stored entry per virtual page. The entries load from
//          the configuration port and are read combinationally by page index.
// Assumes: a write becomes visible only after the clock edge that takes it,
//          so a read in the same cycle sees the old value.
module xlat_table
    import xlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [VPN_W-1:0]   wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [VPN_W-1:0]   rd_idx,
    output pte_t               rd_pte
);
    pte_t tbl_q [N_PAGES];
    pte_t wr_pte;

    // Pick the kept fields out of the written word
    always_comb begin
        wr_pte.valid = wr_data[BIT_VALID];
        wr_pte.pfn   = wr_data[BIT_PFN_L +: PFN_W];
        wr_pte.wprot = wr_data[BIT_WP];
    end

    logic unused_rsvd;
    assign unused_rsvd = ^wr_data[BIT_WP-1:0];

    for (genvar g = 0; g < N_PAGES; g++) begin : g_entry
        // Clear entry g on reset, otherwise load it when it is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_q[g] <= '0;
            end else if (wr_en && (wr_idx == VPN_W'(g))) begin
                tbl_q[g] <= wr_pte;
            end
        end
    end

    // Read port: the selected entry as it stands before this edge
    assign rd_pte = tbl_q[rd_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tbl_q[$past(wr_idx)] ==
                   {$past(wr_data[BIT_VALID]), $past(wr_data[BIT_PFN_L +: PFN_W]),
                    $past(wr_data[BIT_WP])}));                               // R8
endmodule

// File: rtl/xlat_lookup.sv
// Module xlat_lookup
// Purpose: combinational part of the translation. It turns one entry, the
//          access type and the offset into a physical address or a fault.
// Assumes: the caller registers the outputs. An invalid page takes priority
//          over write protection.
module xlat_lookup
    import xlat_pkg::*;
(
    input  pte_t             pte,
    input  logic             is_write,
    input  logic [OFF_W-1:0] offset,
    output logic [PA_W-1:0]  paddr,
    output logic             page_fault,
    output logic             prot_fault
);
    // Classify the access, then build the address only when it may proceed
    always_comb begin
        page_fault = !pte.valid;
        prot_fault = pte.valid && pte.wprot && is_write;
        if (page_fault || prot_fault) begin
            paddr = '0;
        end else begin
            paddr = {pte.pfn, offset};
        end
    end

    always_comb begin
        AST_LOOKUP_EXCL: assert (!(page_fault && prot_fault));               // R9
    end
endmodule

// File: rtl/xlat_mmu.sv
// Module xlat_mmu
// Purpose: top of the paged translator. It joins the table, the lookup
//          logic and the single response register stage.
// Assumes: one request per cycle at most. The response is not held, so it
//          is valid only in the cycle after its request.
module xlat_mmu
    import xlat_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [VPN_W-1:0]   cfg_idx,
    input  logic [ENTRY_W-1:0] cfg_entry,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_page_fault,
    output logic               rsp_prot_fault
);
    pte_t            cur_pte;
    logic [PA_W-1:0] nxt_paddr;
    logic            nxt_pf;
    logic            nxt_wf;

    xlat_table u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_data (cfg_entry),
        .rd_idx  (req_vaddr[VA_W-1 -: VPN_W]),
        .rd_pte  (cur_pte)
    );

    xlat_lookup u_lookup (
        .pte        (cur_pte),
        .is_write   (req_write),
        .offset     (req_vaddr[OFF_W-1:0]),
        .paddr      (nxt_paddr),
        .page_fault (nxt_pf),
        .prot_fault (nxt_wf)
    );

    // Response stage: capture the result of an accepted request, else idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_paddr      <= '0;
            rsp_page_fault <= 1'b0;
            rsp_prot_fault <= 1'b0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_paddr      <= req_valid ? nxt_paddr : '0;
            rsp_page_fault <= req_valid && nxt_pf;
            rsp_prot_fault <= req_valid && nxt_wf;
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);                                            // R2
    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);                                          // R2
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_page_fault || rsp_prot_fault ||
                       rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))); // R3
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_page_fault || rsp_prot_fault) |-> (rsp_paddr == '0));           // R4
    AST_READ_NOT_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !rsp_prot_fault);                      // R5
    AST_FAULTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_page_fault && rsp_prot_fault));                                // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_page_fault && !rsp_prot_fault));                // R9
endmodule

// File: tb/xlat_mmu_tb.sv
module xlat_mmu_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 10;

    // Vector: {write, vaddr[7:0], exp_paddr[7:0], exp_page_fault, exp_prot_fault}
    localparam logic [18:0] VEC [N_VEC] = '{
        {1'b0, 8'h1F, 8'hBF, 1'b0, 1'b0},   // R3 page0 -> frame5 read
        {1'b1, 8'h00, 8'hA0, 1'b0, 1'b0},   // R3 page0 write, no protect
        {1'b0, 8'h25, 8'h00, 1'b1, 1'b0},   // R4 page1 invalid (frame bits set)
        {1'b1, 8'h3A, 8'h00, 1'b1, 1'b0},   // R4 page1 invalid write
        {1'b0, 8'h4C, 8'hAC, 1'b0, 1'b0},   // R6 R7 page2 aliases frame5
        {1'b1, 8'h41, 8'hA1, 1'b0, 1'b0},   // R6 R7 page2 write
        {1'b0, 8'h63, 8'h23, 1'b0, 1'b0},   // R5 page3 protected read ok
        {1'b1, 8'h63, 8'h00, 1'b0, 1'b1},   // R5 page3 protected write
        {1'b1, 8'h9E, 8'h1E, 1'b0, 1'b0},   // R3 page4 frame0
        {1'b0, 8'hE0, 8'h00, 1'b1, 1'b0}    // R1 page7 still invalid
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we;
    logic [2:0] cfg_idx;
    logic [7:0] cfg_entry;
    logic       req_valid;
    logic       req_write;
    logic [7:0] req_vaddr;
    logic       rsp_valid;
    logic [7:0] rsp_paddr;
    logic       rsp_page_fault;
    logic       rsp_prot_fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_mmu u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_idx        (cfg_idx),
        .cfg_entry      (cfg_entry),
        .req_valid      (req_valid),
        .req_write      (req_write),
        .req_vaddr      (req_vaddr),
        .rsp_valid      (rsp_valid),
        .rsp_paddr      (rsp_paddr),
        .rsp_page_fault (rsp_page_fault),
        .rsp_prot_fault (rsp_prot_fault)
    );

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual {valid,paddr,pf,wf}=%h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] idx, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_entry = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request and compare the response in the following cycle
    task automatic translate(input string req, input logic wr, input logic [7:0] va,
                             input logic [7:0] pa, input logic pf, input logic wf);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {rsp_valid, rsp_paddr, rsp_page_fault, rsp_prot_fault}, {1'b1, pa, pf, wf});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_entry = '0;
        req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {rsp_valid, rsp_paddr, rsp_page_fault, rsp_prot_fault}, 11'h0);
        for (int p = 0; p < 8; p++) begin
            translate("R1 all pages invalid", 1'b0, 8'(p * 32 + 5), 8'h00, 1'b1, 1'b0);
        end

        cfg_write(3'd0, 8'hD0);
        cfg_write(3'd1, 8'h75);
        cfg_write(3'd2, 8'hD7);
        cfg_write(3'd3, 8'h98);
        cfg_write(3'd4, 8'h80);

        for (int i = 0; i < N_VEC; i++) begin
            translate("R3-vector", VEC[i][18], VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R2 R9: no request, no response and no fault flags
        @(negedge clk);
        check("R2 R9 idle cycle", {rsp_valid, rsp_paddr, rsp_page_fault, rsp_prot_fault}, 11'h0);

        // R8: table write and translation of page4 in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd4; cfg_entry = 8'hE0;
        req_valid = 1'b1; req_write = 1'b0; req_vaddr = 8'h85;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R8 old entry used", {rsp_valid, rsp_paddr, rsp_page_fault, rsp_prot_fault},
              {1'b1, 8'h05, 1'b0, 1'b0});
        translate("R8 new entry next", 1'b0, 8'h85, 8'hC5, 1'b0, 1'b0);

        // R7: only reserved bits differ, result unchanged
        cfg_write(3'd4, 8'hE7);
        translate("R7 reserved ignored", 1'b1, 8'h85, 8'hC5, 1'b0, 1'b0);

        // R1: reset in the middle of the run empties the table
        do_reset();
        @(negedge clk);
        check("R1 idle after re-reset", {rsp_valid, rsp_paddr, rsp_page_fault, rsp_prot_fault}, 11'h0);
        translate("R1 page0 cleared", 1'b0, 8'h1F, 8'h00, 1'b1, 1'b0);
        translate("R1 page4 cleared", 1'b1, 8'h85, 8'h00, 1'b1, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule